// File: doc/BRIEF.md
# Narrow Binary Field Multiplier (64/96-bit)

This block multiplies two elements of a small binary extension field for authenticated-encryption modes built on narrow cipher blocks. A mode input picks one of two fields: GF(2^64) reduced by t^64 + t^4 + t^3 + t + 1, or GF(2^96) reduced by t^96 + t^10 + t^9 + t^6 + 1. Operands arrive already in plain polynomial order: bit i of a bus is the coefficient of t^i. The block does no bit or byte reordering and keeps no key.

A multiply is requested by holding `start` high for a cycle with both operands and the mode valid. The block forms the carry-less product from 64-bit and 32-bit limbs and folds the upper half back with shifts and XORs. It registers the reduced value and raises `done` in the following cycle. The result register holds its value while `start` is low, so back-to-back requests give one result per cycle.

Top module: `gfm_narrow_mul`

## Requirements
- R1: While reset is asserted and in the cycles after it is released, before any request, `done` is 0 and `prod` is all zeros.
- R2: `done` is 1 in exactly the cycle after a clock edge that sampled `start` high, and 0 after an edge that sampled `start` low.
- R3: After an edge that sampled `start` low, `prod` keeps its previous value whatever the operand and mode inputs do.
- R4: With `mode_wide` = 0, `prod[63:0]` after a request equals opa[63:0] times opb[63:0] modulo t^64 + t^4 + t^3 + t + 1, with bit i as the coefficient of t^i.
- R5: With `mode_wide` = 0, `prod[95:64]` after a request is zero.
- R6: With `mode_wide` = 0, bits 95:64 of both operands have no effect on `prod`.
- R7: With `mode_wide` = 1, `prod` after a request equals opa times opb modulo t^96 + t^10 + t^9 + t^6 + 1, all 96 bits of both operands used.
- R8: Multiplying by the element 1 (only bit 0 set) returns the other operand unchanged in either mode (its low 64 bits in narrow mode).
- R9: The top basis element times t reduces to the low terms of the field polynomial: t^63 times t gives 0x1B in narrow mode, t^95 times t gives 0x641 in wide mode.
- R10: With `start` held high on consecutive cycles, each cycle's result reflects the operands and mode sampled on the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request: sample operands and mode on this edge |
| mode_wide | input | 1 | 0 selects the 64-bit field, 1 the 96-bit field |
| opa | input | 96 | First operand, bit i = coefficient of t^i |
| opb | input | 96 | Second operand, bit i = coefficient of t^i |
| done | output | 1 | Result valid, one cycle after a request |
| prod | output | 96 | Reduced product; upper 32 bits zero in 64-bit mode |

## Verification
All arithmetic is combinational between the operand ports and the result register, so a wrong partial product, a misplaced limb or a missing fold term appears in `prod` in the very cycle after the request that exercises it. A sweep over every pair of basis elements in both fields touches each partial-product bit and each fold tap individually, and top-bit pairs expose an error in the wrap-around term that would otherwise hide. A stuck or leaky result enable shows one cycle later as a changed `prod` while `start` is low, and a bad handshake flop shows as `done` misaligned with the request.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  // limb and field widths
  localparam int unsigned NARROW_W = 64;
  localparam int unsigned WIDE_W   = 96;
  localparam int unsigned LIMB_LO  = 64;
  localparam int unsigned LIMB_HI  = WIDE_W - LIMB_LO;
  localparam int unsigned SLICE_W  = 32;
  localparam int unsigned PROD_W   = 2 * WIDE_W;

  // middle terms of the reduction polynomials (constant term implied)
  localparam logic [NARROW_W-1:0] NARROW_TAPS = NARROW_W'('h1A);
  localparam logic [WIDE_W-1:0]   WIDE_TAPS   = WIDE_W'('h640);

  typedef enum logic {
    FIELD_64 = 1'b0,
    FIELD_96 = 1'b1
  } gfm_field_e;
endpackage

// File: rtl/gfm_rst_sync.sv
module gfm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gfm_clmul.sv
module gfm_clmul #(
  parameter int unsigned AW = 64,
  parameter int unsigned BW = 64
) (
  input  logic [AW-1:0]    a_i,
  input  logic [BW-1:0]    b_i,
  output logic [AW+BW-2:0] p_o
);
  localparam int unsigned PW = AW + BW - 1;

  logic [PW-1:0] rows [BW];
  logic [PW-1:0] acc;

  // one shifted copy of a per bit of b
  genvar gj;
  generate
    for (gj = 0; gj < BW; gj++) begin : g_row
      assign rows[gj] = b_i[gj] ? ({{(BW-1){1'b0}}, a_i} << gj) : '0;
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int j = 0; j < BW; j++) acc ^= rows[j];
  end

  assign p_o = acc;

  // R8: the unit multiplier copies the other operand
  always_comb begin
    if (b_i == BW'(1)) begin
      assert_unit_multiplier_R8: assert (p_o == PW'(a_i));
    end
  end
endmodule

// File: rtl/gfm_fold.sv
module gfm_fold #(
  parameter int unsigned N     = 64,
  parameter int unsigned SLICE = 32,
  parameter logic [N-1:0] TAPS = 'h1A
) (
  input  logic [N-1:0] hi_i,
  input  logic [N-1:0] lo_i,
  output logic [N-1:0] red_o
);
  localparam int unsigned NSL = N / SLICE;

  logic [N-1:0] spill;
  logic [N-1:0] hi_f;
  logic [N-1:0] spread;

  // pass 1: bits that the tap shifts push past t^(N-1) come back down
  always_comb begin
    spill = '0;
    for (int k = 1; k < N; k++) begin
      if (TAPS[k]) spill ^= hi_i >> (N - k);
    end
  end

  assign hi_f = hi_i ^ spill;

  // pass 2: multiply the folded high part by the polynomial's low terms
  always_comb begin
    spread = hi_f;
    for (int k = 1; k < N; k++) begin
      if (TAPS[k]) spread ^= hi_f << k;
    end
  end

  // combine with the low half slice by slice
  genvar gs;
  generate
    for (gs = 0; gs < NSL; gs++) begin : g_slice
      assign red_o[gs*SLICE +: SLICE] = lo_i[gs*SLICE +: SLICE] ^ spread[gs*SLICE +: SLICE];
    end
  endgenerate

  // R4, R7: nothing above t^(N-1) means nothing to reduce
  always_comb begin
    if (hi_i == '0) begin
      assert_fold_passthru_R7: assert (red_o == lo_i);
    end
  end
endmodule

// File: rtl/gfm_narrow_mul.sv
module gfm_narrow_mul
  import gfm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_wide,
  input  logic [WIDE_W-1:0] opa,
  input  logic [WIDE_W-1:0] opb,
  output logic              done,
  output logic [WIDE_W-1:0] prod
);
  localparam int unsigned F_W  = 2 * LIMB_LO - 1;
  localparam int unsigned E_W  = LIMB_LO + LIMB_HI - 1;
  localparam int unsigned D_W  = 2 * LIMB_HI - 1;

  gfm_field_e field;
  logic rst_sync_n;

  logic [LIMB_LO-1:0] a_lo, b_lo;
  logic [LIMB_HI-1:0] a_hi, b_hi;
  logic [F_W-1:0]     f_pp;
  logic [E_W-1:0]     e_lh, e_hl, e_pp;
  logic [D_W-1:0]     d_pp;
  logic [PROD_W-1:0]  full;
  logic [NARROW_W-1:0] red64;
  logic [WIDE_W-1:0]   red96;
  logic [WIDE_W-1:0]   res_d;

  logic [WIDE_W-1:0] prod_q, prod_d;
  logic              done_q, done_d;

  assign field = gfm_field_e'(mode_wide);

  gfm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // limbs; upper limbs isolated in narrow mode
  assign a_lo = opa[LIMB_LO-1:0];
  assign b_lo = opb[LIMB_LO-1:0];
  assign a_hi = (field == FIELD_96) ? opa[WIDE_W-1:LIMB_LO] : '0;
  assign b_hi = (field == FIELD_96) ? opb[WIDE_W-1:LIMB_LO] : '0;

  gfm_clmul #(.AW(LIMB_LO), .BW(LIMB_LO)) u_ll (.a_i(a_lo), .b_i(b_lo), .p_o(f_pp));
  gfm_clmul #(.AW(LIMB_LO), .BW(LIMB_HI)) u_lh (.a_i(a_lo), .b_i(b_hi), .p_o(e_lh));
  gfm_clmul #(.AW(LIMB_LO), .BW(LIMB_HI)) u_hl (.a_i(b_lo), .b_i(a_hi), .p_o(e_hl));
  gfm_clmul #(.AW(LIMB_HI), .BW(LIMB_HI)) u_hh (.a_i(a_hi), .b_i(b_hi), .p_o(d_pp));

  assign e_pp = e_lh ^ e_hl;

  // d at t^128, e at t^64, f at t^0
  assign full = {{(PROD_W-F_W){1'b0}}, f_pp}
              ^ {{(PROD_W-E_W-LIMB_LO){1'b0}}, e_pp, {LIMB_LO{1'b0}}}
              ^ {{(PROD_W-D_W-2*LIMB_LO){1'b0}}, d_pp, {(2*LIMB_LO){1'b0}}};

  gfm_fold #(.N(NARROW_W), .SLICE(SLICE_W), .TAPS(NARROW_TAPS)) u_fold64 (
    .hi_i  ({1'b0, f_pp[F_W-1:NARROW_W]}),
    .lo_i  (f_pp[NARROW_W-1:0]),
    .red_o (red64)
  );

  gfm_fold #(.N(WIDE_W), .SLICE(SLICE_W), .TAPS(WIDE_TAPS)) u_fold96 (
    .hi_i  (full[PROD_W-1:WIDE_W]),
    .lo_i  (full[WIDE_W-1:0]),
    .red_o (red96)
  );

  assign res_d = (field == FIELD_96) ? red96 : {{(WIDE_W-NARROW_W){1'b0}}, red64};

  // next state
  always_comb begin
    prod_d = prod_q;
    if (start) prod_d = res_d;
    done_d = start;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prod_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (start) prod_q <= prod_d;
    end
  end

  assign prod = prod_q;
  assign done = done_q;

  assert_done_after_start_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start |=> done);
  assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !start |=> !done);
  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !start |=> $stable(prod));
  assert_narrow_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start && !mode_wide) |=> (prod[WIDE_W-1:NARROW_W] == '0));
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (!done && prod == '0));
endmodule

// File: tb/test_gfm_narrow_mul.sv
module test_gfm_narrow_mul;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic        mode_wide;
  logic [95:0] opa, opb;
  logic        done;
  logic [95:0] prod;

  int checks;
  int failures;

  gfm_narrow_mul i_gfm_narrow_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode_wide (mode_wide),
    .opa       (opa),
    .opb       (opb),
    .done      (done),
    .prod      (prod)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // shift-and-add reference over the selected field
  function automatic logic [95:0] ref_mul(input logic [95:0] a, input logic [95:0] b, input logic w);
    logic [95:0] mask, poly, r, aa;
    int n;
    n    = w ? 96 : 64;
    mask = w ? {96{1'b1}} : {32'h0, {64{1'b1}}};
    poly = w ? 96'h641 : 96'h1B;
    aa   = a & mask;
    r    = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic top;
      top = r[n-1];
      r   = (r << 1) & mask;
      if (top)  r ^= poly;
      if (b[i]) r ^= aa;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // caller is at a falling edge; result checked at the next one
  task automatic issue(input logic [95:0] a, input logic [95:0] b, input logic w, input string tag);
    logic [95:0] exp;
    exp       = ref_mul(a, b, w);
    opa       = a;
    opb       = b;
    mode_wide = w;
    start     = 1'b1;
    @(negedge clk);
    chk({tag, " done"}, {95'h0, done}, 96'h1);
    chk(tag, prod, exp);
  endtask

  function automatic logic [95:0] rnd96();
    return {$urandom, $urandom, $urandom};
  endfunction

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [95:0] held;
    checks = 0; failures = 0;
    start = 1'b0; mode_wide = 1'b0; opa = '0; opb = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset done", {95'h0, done}, 96'h0);
    chk("R1 reset prod", prod, 96'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release done", {95'h0, done}, 96'h0);
    chk("R1 after release prod", prod, 96'h0);

    // R9 wrap-around terms
    issue(96'h1 << 63, 96'h2, 1'b0, "R9 narrow");
    chk("R9 narrow value", prod, 96'h1B);
    issue(96'h1 << 95, 96'h2, 1'b1, "R9 wide");
    chk("R9 wide value", prod, 96'h641);

    // R8 identity
    for (int i = 0; i < 8; i++) begin
      logic [95:0] x;
      x = rnd96();
      issue(x, 96'h1, 1'b1, "R8 wide identity");
      chk("R8 wide copy", prod, x);
      issue(96'h1, x, 1'b0, "R8 narrow identity");
      chk("R8 narrow copy", prod, {32'h0, x[63:0]});
    end

    // R4, R10: every basis pair in the narrow field, back to back
    for (int i = 0; i < 64; i++)
      for (int j = 0; j < 64; j++)
        issue(96'h1 << i, 96'h1 << j, 1'b0, "R4 basis");

    // R7, R10: every basis pair in the wide field, back to back
    for (int i = 0; i < 96; i++)
      for (int j = 0; j < 96; j++)
        issue(96'h1 << i, 96'h1 << j, 1'b1, "R7 basis");

    // random operands in both fields, alternating mode (R10)
    for (int i = 0; i < 300; i++) begin
      issue(rnd96(), rnd96(), 1'b1, "R7 random");
      issue({32'h0, rnd96()[63:0]}, {32'h0, rnd96()[63:0]}, 1'b0, "R4 random");
      chk("R5 upper zero", {64'h0, prod[95:64]}, 96'h0);
    end

    // R6: upper operand bits ignored in narrow mode
    for (int i = 0; i < 100; i++) begin
      logic [95:0] a, b;
      a = rnd96(); b = rnd96();
      issue(a, b, 1'b0, "R6 dirty upper");
      chk("R6 vs clean", prod, ref_mul({32'h0, a[63:0]}, {32'h0, b[63:0]}, 1'b0));
      chk("R5 dirty upper zero", {64'h0, prod[95:64]}, 96'h0);
    end

    // R2, R3: idle cycles hold the result and drop done
    issue(rnd96(), rnd96(), 1'b1, "R3 setup");
    held  = prod;
    start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      opa = rnd96(); opb = rnd96(); mode_wide = i[0];
      @(negedge clk);
      chk("R2 idle done", {95'h0, done}, 96'h0);
      chk("R3 idle hold", prod, held);
    end
    issue(96'h3, 96'h3, 1'b0, "R2 restart");
    chk("R2 restart value", prod, 96'h5);
    start = 1'b0;
    @(negedge clk);
    chk("R2 single pulse done", {95'h0, done}, 96'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule